// File: doc/BRIEF.md
# Interrupt Entry and Return Frame Sequencer

This block carries out the hardware side of taking an interrupt in a small CPU. The CPU has an 8-bit datapath and a 19-bit program counter that counts half-bytes. When the core accepts an interrupt, it presents its current stack pointer, program counter, 16-bit HA register and PSW, together with the source number and level of the accepted interrupt. The sequencer first moves the stack pointer down by six. It then writes a six-byte frame through a byte-wide memory port, one byte per cycle. After that it loads the interrupt level into the PSW mask field and fetches the 16-bit handler address from the vector table. The updated state is handed back with a one-cycle completion pulse.

A return request runs the reverse operation. The sequencer reads the six frame bytes upward from the given stack pointer, rebuilds PSW, PC and HA, and reports the stack pointer raised by six. General data and address registers are not part of the frame, and the block does not arbitrate between interrupt sources. The memory port reads combinationally: read data belongs to the address presented in the same cycle.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are all low.
- R2: An accepted interrupt takes `sp_in - 6` (modulo 2^16) as the frame base, and `sp_o` equals that base when `done` pulses.
- R3: In the six cycles right after acceptance, `mem_we` is high and the addresses run from base+5 down to base. The bytes written, in that order, are HA[15:8], HA[7:0], the packed PC byte, PC[16:9], PC[8:1], and the PSW as it was on entry.
- R4: The packed PC byte holds PC[0] in bit 0 and PC[18:17] in bits 2:1. Bits 7:3 are zero.
- R5: After entry, `psw_o` bits 7:6 equal the accepted level and bits 5:0 equal the entry PSW. `ha_o` equals the entry HA.
- R6: In the two cycles after the last frame write, `mem_re` is high at address VEC_BASE + 2·source and then at that address + 1. The byte read first is the low byte of the handler, and `pc_o` becomes handler·2 with bits 18:17 zero.
- R7: `busy` stays high for exactly 8 cycles on entry and 6 cycles on return. `done` then pulses for one cycle with `busy` low, and the block is idle in the following cycle.
- R8: A return reads addresses `sp_in`+0 to `sp_in`+5 in six consecutive cycles. It restores the PSW from offset 0, PC[8:1] from offset 1, PC[16:9] from offset 2, PC[18:17] and PC[0] from bits 2:1 and 0 of offset 3, and HA low then high from offsets 4 and 5. `sp_o` becomes `sp_in` + 6.
- R9: Requests that arrive while `busy` is high are ignored. When an entry and a return are requested in the same idle cycle, the entry is taken.
- R10: A frame written on entry and read back by a return yields the original PC, HA and PSW. This holds when the stack pointer wraps below address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| accept_req | input | 1 | Start interrupt entry (sampled when idle) |
| ret_req | input | 1 | Start interrupt return (sampled when idle) |
| irq_src | input | SRC_W | Number of the accepted source |
| irq_lvl | input | LVL_W | Level of the accepted source |
| sp_in | input | SP_W | Current stack pointer |
| pc_in | input | 19 | Return address (half-byte units) |
| ha_in | input | 16 | HA register |
| psw_in | input | 8 | Current PSW |
| mem_addr | output | SP_W | Byte address of the memory port |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read data for the current address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_o | output | SP_W | Resulting stack pointer |
| pc_o | output | 19 | Resulting program counter |
| ha_o | output | 16 | Resulting HA |
| psw_o | output | 8 | Resulting PSW |

## Verification
Some properties are checked on every cycle:
- reads and writes never overlap;
- consecutive frame writes step down by one address, and consecutive reads step up by one;
- the upper bits of the packed PC byte stay zero;
- the mask field matches the captured level at completion;
- `done` is a single-cycle pulse with `busy` low.

Other behaviour only shows up in the bench's sweeps over every source and level. This covers the exact byte placed at each frame offset, the handler address built from the vector bytes, the round trip from entry to return, stack wrap-around, and the rule that requests are ignored while busy and that entry wins over return.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  localparam int PC_W        = 19;
  localparam int HA_W        = 16;
  localparam int PSW_W       = 8;
  localparam int FRAME_BYTES = 6;
  localparam int STEP_W      = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PUSH,
    PH_VEC,
    PH_POP,
    PH_FIN
  } phase_e;

  // Byte written at push step k (step 0 goes to the highest address).
  function automatic logic [7:0] push_byte(input logic [STEP_W-1:0] k,
                                           input logic [HA_W-1:0]   ha,
                                           input logic [PC_W-1:0]   pc,
                                           input logic [PSW_W-1:0]  psw);
    logic [7:0] b;
    case (k)
      3'd0:    b = ha[15:8];
      3'd1:    b = ha[7:0];
      3'd2:    b = {5'b00000, pc[18:17], pc[0]};
      3'd3:    b = pc[16:9];
      3'd4:    b = pc[8:1];
      default: b = psw;
    endcase
    return b;
  endfunction

  // Frame offset (from the new stack pointer) of push step k.
  function automatic logic [STEP_W-1:0] push_offset(input logic [STEP_W-1:0] k);
    return 3'(FRAME_BYTES - 1) - k;
  endfunction

  // Handler byte address to half-byte program counter.
  function automatic logic [PC_W-1:0] handler_pc(input logic [15:0] h);
    return {2'b00, h, 1'b0};
  endfunction
endpackage

// File: rtl/irq_frame_ctrl.sv
module irq_frame_ctrl
  import irq_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_req,
  input  logic              ret_req,
  output phase_e            phase,
  output logic [STEP_W-1:0] step,
  output logic              ret_mode,
  output logic              start_acc,
  output logic              start_ret,
  output logic              busy,
  output logic              done
);
  localparam logic [STEP_W-1:0] LAST_FRAME = STEP_W'(FRAME_BYTES - 1);
  localparam logic [STEP_W-1:0] LAST_VEC   = STEP_W'(1);

  assign start_acc = (phase == PH_IDLE) && accept_req;
  assign start_ret = (phase == PH_IDLE) && !accept_req && ret_req;
  assign busy      = (phase == PH_PUSH) || (phase == PH_VEC) || (phase == PH_POP);
  assign done      = (phase == PH_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      step     <= '0;
      ret_mode <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          step <= '0;
          if (start_acc) begin
            phase    <= PH_PUSH;
            ret_mode <= 1'b0;
          end else if (start_ret) begin
            phase    <= PH_POP;
            ret_mode <= 1'b1;
          end
        end
        PH_PUSH: begin
          if (step == LAST_FRAME) begin
            phase <= PH_VEC;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        PH_VEC: begin
          if (step == LAST_VEC) begin
            phase <= PH_FIN;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        PH_POP: begin
          if (step == LAST_FRAME) begin
            phase <= PH_FIN;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          step  <= '0;
        end
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(start_acc || start_ret));
endmodule

// File: rtl/irq_frame_regs.sv
module irq_frame_regs
  import irq_frame_pkg::*;
#(
  parameter int SP_W  = 16,
  parameter int SRC_W = 3,
  parameter int LVL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [STEP_W-1:0] step,
  input  logic              start_acc,
  input  logic              start_ret,
  input  logic              done,
  input  logic              ret_mode,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [LVL_W-1:0]  irq_lvl,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [HA_W-1:0]   ha_in,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [7:0]        rdata,
  output logic [7:0]        wdata,
  output logic [SRC_W-1:0]  src_q,
  output logic [SP_W-1:0]   sp_q,
  output logic [PC_W-1:0]   pc_q,
  output logic [HA_W-1:0]   ha_q,
  output logic [PSW_W-1:0]  psw_q
);
  localparam logic [SP_W-1:0]   FRAME_SZ   = SP_W'(FRAME_BYTES);
  localparam logic [STEP_W-1:0] LAST_FRAME = STEP_W'(FRAME_BYTES - 1);
  localparam int                IM_TOP     = PSW_W - 1;

  logic [LVL_W-1:0] lvl_q;

  assign wdata = push_byte(step, ha_q, pc_q, psw_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      pc_q  <= '0;
      ha_q  <= '0;
      psw_q <= '0;
      src_q <= '0;
      lvl_q <= '0;
    end else if (start_acc) begin
      sp_q  <= sp_in - FRAME_SZ;
      pc_q  <= pc_in;
      ha_q  <= ha_in;
      psw_q <= psw_in;
      src_q <= irq_src;
      lvl_q <= irq_lvl;
    end else if (start_ret) begin
      sp_q <= sp_in;
    end else begin
      case (phase)
        PH_PUSH: begin
          if (step == LAST_FRAME) psw_q[IM_TOP -: LVL_W] <= lvl_q;
        end
        PH_VEC: begin
          if (step == '0) begin
            pc_q[8:1] <= rdata;
            pc_q[0]   <= 1'b0;
          end else begin
            pc_q[16:9]  <= rdata;
            pc_q[18:17] <= 2'b00;
          end
        end
        PH_POP: begin
          case (step)
            3'd0: psw_q <= rdata;
            3'd1: pc_q[8:1] <= rdata;
            3'd2: pc_q[16:9] <= rdata;
            3'd3: begin
              pc_q[18:17] <= rdata[2:1];
              pc_q[0]     <= rdata[0];
            end
            3'd4: ha_q[7:0] <= rdata;
            default: begin
              ha_q[15:8] <= rdata;
              sp_q       <= sp_q + FRAME_SZ;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  // R5
  im_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ret_mode) |-> (psw_q[IM_TOP -: LVL_W] == lvl_q));

  // R2
  frame_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (sp_q == $past(sp_in) - FRAME_SZ));
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int              SP_W     = 16,
  parameter int              SRC_W    = 3,
  parameter int              LVL_W    = 2,
  parameter logic [SP_W-1:0] VEC_BASE = 16'h4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_req,
  input  logic             ret_req,
  input  logic [SRC_W-1:0] irq_src,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [SP_W-1:0]  sp_in,
  input  logic [18:0]      pc_in,
  input  logic [15:0]      ha_in,
  input  logic [7:0]       psw_in,
  output logic [SP_W-1:0]  mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             mem_we,
  output logic             mem_re,
  input  logic [7:0]       mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [SP_W-1:0]  sp_o,
  output logic [18:0]      pc_o,
  output logic [15:0]      ha_o,
  output logic [7:0]       psw_o
);
  localparam int PAD_W = SP_W - SRC_W - 1;

  phase_e            phase;
  logic [STEP_W-1:0] step;
  logic              ret_mode;
  logic              start_acc;
  logic              start_ret;
  logic [SRC_W-1:0]  src_q;
  logic [SP_W-1:0]   sp_q;
  logic [7:0]        wdata;
  logic [SP_W-1:0]   vec_addr;
  logic              pack_step;

  irq_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_req (accept_req),
    .ret_req    (ret_req),
    .phase      (phase),
    .step       (step),
    .ret_mode   (ret_mode),
    .start_acc  (start_acc),
    .start_ret  (start_ret),
    .busy       (busy),
    .done       (done)
  );

  irq_frame_regs #(
    .SP_W  (SP_W),
    .SRC_W (SRC_W),
    .LVL_W (LVL_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .step      (step),
    .start_acc (start_acc),
    .start_ret (start_ret),
    .done      (done),
    .ret_mode  (ret_mode),
    .irq_src   (irq_src),
    .irq_lvl   (irq_lvl),
    .sp_in     (sp_in),
    .pc_in     (pc_in),
    .ha_in     (ha_in),
    .psw_in    (psw_in),
    .rdata     (mem_rdata),
    .wdata     (wdata),
    .src_q     (src_q),
    .sp_q      (sp_q),
    .pc_q      (pc_o),
    .ha_q      (ha_o),
    .psw_q     (psw_o)
  );

  assign vec_addr  = VEC_BASE + {{PAD_W{1'b0}}, src_q, 1'b0} + SP_W'(step);
  assign pack_step = mem_we && (step == 3'd2);

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (phase)
      PH_PUSH: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q + SP_W'(push_offset(step));
        mem_wdata = wdata;
      end
      PH_VEC: begin
        mem_re   = 1'b1;
        mem_addr = vec_addr;
      end
      PH_POP: begin
        mem_re   = 1'b1;
        mem_addr = sp_q + SP_W'(step);
      end
      default: ;
    endcase
  end

  assign sp_o = sp_q;

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R3
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

  // R8
  read_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  // R4
  pack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pack_step |-> (mem_wdata[7:3] == 5'b00000));
endmodule

// File: tb/sim_irq_frame_seq.sv
module sim_irq_frame_seq;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_req = 1'b0;
  logic        ret_req = 1'b0;
  logic [2:0]  irq_src = '0;
  logic [1:0]  irq_lvl = '0;
  logic [15:0] sp_in = '0;
  logic [18:0] pc_in = '0;
  logic [15:0] ha_in = '0;
  logic [7:0]  psw_in = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic        busy;
  logic        done;
  logic [15:0] sp_o;
  logic [18:0] pc_o;
  logic [15:0] ha_o;
  logic [7:0]  psw_o;

  int checks = 0;
  int failures = 0;

  logic [7:0] mem [0:511];

  always #(CLK_PER/2) clk = ~clk;

  function automatic int mkey(input logic [15:0] a);
    return int'({a[14], a[7:0]});
  endfunction

  function automatic logic [15:0] vh(input int n);
    return 16'(16'h1357 + n * 16'h2468);
  endfunction

  assign mem_rdata = mem[mkey(mem_addr)];

  irq_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .accept_req(accept_req), .ret_req(ret_req),
    .irq_src(irq_src), .irq_lvl(irq_lvl), .sp_in(sp_in), .pc_in(pc_in),
    .ha_in(ha_in), .psw_in(psw_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .sp_o(sp_o), .pc_o(pc_o), .ha_o(ha_o), .psw_o(psw_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_accept(input int src, input int lvl, input logic [15:0] sp,
                            input logic [18:0] pc, input logic [15:0] ha,
                            input logic [7:0] psw, input bit poke, input bit both);
    logic [15:0] base;
    logic [7:0]  eb [6];
    logic [15:0] h;
    base  = sp - 16'd6;
    eb[0] = 8'(ha >> 8);
    eb[1] = 8'(ha & 16'hFF);
    eb[2] = 8'(((pc >> 17) << 1) | (pc & 19'h1));
    eb[3] = 8'((pc >> 9) & 19'hFF);
    eb[4] = 8'((pc >> 1) & 19'hFF);
    eb[5] = psw;
    h     = vh(src);
    @(negedge clk);
    irq_src = 3'(src); irq_lvl = 2'(lvl);
    sp_in = sp; pc_in = pc; ha_in = ha; psw_in = psw;
    accept_req = 1'b1; ret_req = both;
    @(negedge clk);
    accept_req = 1'b0; ret_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R7 busy during push", 32'(busy), 1);
      chk("R3 we during push", 32'(mem_we), 1);
      chk("R9 no read during push", 32'(mem_re), 0);
      chk("R3 push address", 32'(mem_addr), 32'(16'(base + 16'(5 - k))));
      chk((k == 2) ? "R4 packed pc byte" : "R3 push data", 32'(mem_wdata), 32'(eb[k]));
      mem[mkey(mem_addr)] = mem_wdata;
      if (poke && k == 2) begin
        accept_req = 1'b1; ret_req = 1'b1;
        sp_in = 16'h1234; pc_in = '0; ha_in = '0; psw_in = 8'hFF;
        irq_src = 3'(src + 1); irq_lvl = 2'(lvl + 1);
      end else begin
        accept_req = 1'b0; ret_req = 1'b0;
      end
      @(negedge clk);
    end
    accept_req = 1'b0; ret_req = 1'b0;
    chk("R6 vector read low", 32'(mem_re), 1);
    chk("R6 vector addr low", 32'(mem_addr), 32'(16'h4000 + 16'(2 * src)));
    chk("R7 busy vec", 32'(busy), 1);
    @(negedge clk);
    chk("R6 vector read high", 32'(mem_re), 1);
    chk("R6 vector addr high", 32'(mem_addr), 32'(16'h4000 + 16'(2 * src) + 16'd1));
    @(negedge clk);
    chk("R7 done after entry", 32'(done), 1);
    chk("R7 busy low at done", 32'(busy), 0);
    chk("R2 sp_o frame base", 32'(sp_o), 32'(base));
    chk("R6 pc_o handler", 32'(pc_o), 32'(h) * 2);
    chk("R5 ha_o kept", 32'(ha_o), 32'(ha));
    chk("R5 psw_o IM", 32'(psw_o), 32'((psw & 8'h3F) | 8'(lvl << 6)));
    @(negedge clk);
    chk("R9 idle after entry", 32'({busy, done, mem_we, mem_re}), 0);
  endtask

  task automatic run_return(input logic [15:0] base, input logic [18:0] pc,
                            input logic [15:0] ha, input logic [7:0] psw);
    @(negedge clk);
    sp_in = base; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R8 read strobe", 32'(mem_re), 1);
      chk("R8 no write", 32'(mem_we), 0);
      chk("R8 pop address", 32'(mem_addr), 32'(16'(base + 16'(k))));
      chk("R7 busy during pop", 32'(busy), 1);
      @(negedge clk);
    end
    chk("R7 done after return", 32'(done), 1);
    chk("R8 sp_o raised", 32'(sp_o), 32'(16'(base + 16'd6)));
    chk("R10 pc restored", 32'(pc_o), 32'(pc));
    chk("R10 ha restored", 32'(ha_o), 32'(ha));
    chk("R8 psw restored", 32'(psw_o), 32'(psw));
    @(negedge clk);
    chk("R7 idle after return", 32'({busy, done}), 0);
  endtask

  initial begin
    #(CLK_PER * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    for (int n = 0; n < 8; n++) begin
      mem[mkey(16'h4000 + 16'(2 * n))]     = vh(n)[7:0];
      mem[mkey(16'h4000 + 16'(2 * n) + 1)] = vh(n)[15:8];
    end
    repeat (3) @(negedge clk);
    chk("R1 reset quiet", 32'({busy, done, mem_we, mem_re}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({busy, done, mem_we, mem_re}), 0);

    for (int i = 0; i < 32; i++) begin
      logic [15:0] sp;
      logic [18:0] pc;
      logic [15:0] ha;
      logic [7:0]  psw;
      sp  = 16'h4020 + 16'(4 * i);
      pc  = 19'(19'h5A5A5 ^ (i * 19'h12345));
      ha  = 16'(16'hC3A0 + i * 257);
      psw = 8'(8'h3F ^ (i * 8'h11));
      run_accept(i % 8, i / 8, sp, pc, ha, psw, (i == 5), (i == 7));
      run_return(sp - 16'd6, pc, ha, psw);
    end

    // R10 stack wrap below zero
    run_accept(6, 3, 16'h0003, 19'h7FFFF, 16'hFFFF, 8'hFF, 1'b0, 1'b0);
    run_return(16'hFFFD, 19'h7FFFF, 16'hFFFF, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule